// File: doc/BRIEF.md
# Interleaved Image Byte Selector

This block picks one configuration image out of a byte stream in which several images have been merged. The merged stream carries a fixed-size chunk of 288 bytes from the first image, then 288 bytes from the second image, and so on up to the last image. The pattern then starts again with the first image. The block takes every byte from an upstream valid/ready source. It passes on only the bytes of the chosen image, in their original order, to a downstream valid/ready sink. All other bytes are drained and dropped.

Two static inputs set the behaviour. The image count gives N, from 1 to 8. The image select is 1-based. A single-cycle restart pulse returns the block to the first byte of the merged stream. Position is tracked with a byte-in-chunk counter and a chunk index, so no divider is needed. The data path is purely combinational between the two handshakes and holds no storage.

Top module: `ilv_image_picker`

## Requirements
- R1: Number the merged bytes from 0 after reset or restart as g. Byte g belongs to image ((g / 288) mod N) + 1, where N is the image count input and the image select input is 1-based.
- R2: Only bytes that belong to the selected image appear on the downstream side. They appear in stream order, each exactly once. No discarded byte ever raises the downstream valid.
- R3: The position advances on every byte accepted upstream, dropped or forwarded. While the current byte belongs to another image, upstream ready is high whatever downstream ready does, so skipping runs at one byte per clock.
- R4: While the current byte belongs to the selected image, upstream ready equals downstream ready and downstream valid equals upstream valid. Stalls therefore neither repeat nor lose a byte.
- R5: In a cycle with restart high, no byte is accepted and the position returns to byte 0 of image 1's first chunk. The next accepted byte is counted as g = 0.
- R6: If the image count is outside 1..8, or the select is 0 or larger than the count, the error output is high, upstream ready is low and downstream valid is low. The position does not move in that state.
- R7: With an image count of 1 and a select of 1, every upstream byte is forwarded.
- R8: After reset, downstream valid is low while upstream valid is low, and the position is at g = 0.
- R9: Selecting the last image (select equal to the count) forwards the final chunk of each round. The position then wraps to image 1 for the next round.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Single-cycle pulse that returns to the start of the merged stream |
| img_count | input | 4 | Number of merged images N (1..8 valid) |
| img_sel | input | 4 | Selected image, 1-based |
| up_data | input | 8 | Merged stream byte |
| up_valid | input | 1 | Upstream byte present |
| up_ready | output | 1 | Byte accepted this cycle when high with up_valid |
| dn_data | output | 8 | Selected image byte |
| dn_valid | output | 1 | Selected byte present |
| dn_ready | input | 1 | Downstream accepts the byte |
| sel_err | output | 1 | Invalid count or select; nothing moves |

## Verification
The hardest case to reach is the wrap from the last chunk of one round to image 1 while the sink is stalling. A wrong chunk index is only visible after thousands of bytes have gone past at the correct rate. The stimulus therefore runs whole rounds of eight 288-byte chunks with the last image selected, toggling both upstream valid and downstream ready from a pseudo-random sequence. The scoreboard advances its own byte index only on observed handshakes, so every wrap, stall and restart is checked against the division formula rather than a counter copy.

// File: rtl/ilv_pick_pkg.sv
package ilv_pick_pkg;
  // Routing decision for the byte currently offered upstream.
  typedef enum logic [1:0] {
    ROUTE_HALT = 2'd0,  // nothing moves (error or restart cycle)
    ROUTE_DROP = 2'd1,  // byte belongs to another image: consume and drop
    ROUTE_PASS = 2'd2   // byte belongs to the selected image: hand downstream
  } route_e;
endpackage

// File: rtl/ilv_sel_check.sv
module ilv_sel_check #(
  parameter int MAX_IMAGES = 8,
  localparam int CNT_W = $clog2(MAX_IMAGES + 1),
  localparam int IDX_W = (MAX_IMAGES > 1) ? $clog2(MAX_IMAGES) : 1
) (
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] sel,
  output logic             sel_ok,
  output logic [IDX_W-1:0] want_idx
);
  function automatic logic legal_pair(input logic [CNT_W-1:0] n, input logic [CNT_W-1:0] s);
    logic n_ok, s_ok;
    n_ok = (n != '0) && (int'(n) <= MAX_IMAGES);
    s_ok = (s != '0) && (s <= n);
    return n_ok && s_ok;
  endfunction

  function automatic logic [IDX_W-1:0] zero_based(input logic [CNT_W-1:0] s);
    logic [CNT_W-1:0] d;
    d = s - CNT_W'(1);
    return IDX_W'(d);
  endfunction

  always_comb begin
    sel_ok   = legal_pair(count, sel);
    want_idx = zero_based(sel);
  end
endmodule

// File: rtl/ilv_chunk_tracker.sv
module ilv_chunk_tracker #(
  parameter int CHUNK_BYTES = 288,
  parameter int MAX_IMAGES  = 8,
  localparam int POS_W = (CHUNK_BYTES > 1) ? $clog2(CHUNK_BYTES) : 1,
  localparam int CNT_W = $clog2(MAX_IMAGES + 1),
  localparam int IDX_W = (MAX_IMAGES > 1) ? $clog2(MAX_IMAGES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] count,
  output logic [POS_W-1:0] byte_pos,
  output logic [IDX_W-1:0] chunk_idx,
  output logic             chunk_end
);
  function automatic logic at_chunk_end(input logic [POS_W-1:0] p);
    return int'(p) == CHUNK_BYTES - 1;
  endfunction

  function automatic logic [IDX_W-1:0] next_chunk(input logic [IDX_W-1:0] idx,
                                                   input logic [CNT_W-1:0] n);
    logic [CNT_W:0] bumped;
    bumped = (CNT_W+1)'(idx) + (CNT_W+1)'(1);
    if (bumped >= {1'b0, n}) return '0;
    return IDX_W'(bumped);
  endfunction

  assign chunk_end = at_chunk_end(byte_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_pos  <= '0;
      chunk_idx <= '0;
    end else if (clear) begin
      byte_pos  <= '0;
      chunk_idx <= '0;
    end else if (step) begin
      if (chunk_end) begin
        byte_pos  <= '0;
        chunk_idx <= next_chunk(chunk_idx, count);
      end else begin
        byte_pos  <= byte_pos + POS_W'(1);
      end
    end
  end

  // R1: position stays inside one chunk and one round
  p_pos_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(byte_pos) < CHUNK_BYTES) && (int'(chunk_idx) < MAX_IMAGES));

  // R1: chunk index only changes across a chunk boundary
  p_chunk_walk_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !(step && chunk_end)) |=> $stable(chunk_idx));

  // R3: position holds when no byte is taken
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !step) |=> $stable(byte_pos));

  // R5: restart returns to the first byte of the first chunk
  p_restart_home_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (byte_pos == '0) && (chunk_idx == '0));
endmodule

// File: rtl/ilv_image_picker.sv
module ilv_image_picker
  import ilv_pick_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CHUNK_BYTES = 288,
  parameter int MAX_IMAGES  = 8,
  localparam int CNT_W = $clog2(MAX_IMAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CNT_W-1:0]  img_count,
  input  logic [CNT_W-1:0]  img_sel,
  input  logic [DATA_W-1:0] up_data,
  input  logic              up_valid,
  output logic              up_ready,
  output logic [DATA_W-1:0] dn_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              sel_err
);
  localparam int POS_W = (CHUNK_BYTES > 1) ? $clog2(CHUNK_BYTES) : 1;
  localparam int IDX_W = (MAX_IMAGES > 1) ? $clog2(MAX_IMAGES) : 1;

  logic             sel_ok;
  logic [IDX_W-1:0] want_idx;
  logic [POS_W-1:0] byte_pos;
  logic [IDX_W-1:0] chunk_idx;
  logic             chunk_end;
  logic             take;
  logic             own_chunk;
  route_e           route;

  ilv_sel_check #(.MAX_IMAGES(MAX_IMAGES)) u_sel (
    .count    (img_count),
    .sel      (img_sel),
    .sel_ok   (sel_ok),
    .want_idx (want_idx)
  );

  ilv_chunk_tracker #(.CHUNK_BYTES(CHUNK_BYTES), .MAX_IMAGES(MAX_IMAGES)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (restart),
    .step      (take),
    .count     (img_count),
    .byte_pos  (byte_pos),
    .chunk_idx (chunk_idx),
    .chunk_end (chunk_end)
  );

  assign own_chunk = (chunk_idx == want_idx);

  always_comb begin
    if (!sel_ok || restart) route = ROUTE_HALT;
    else if (own_chunk)     route = ROUTE_PASS;
    else                    route = ROUTE_DROP;
  end

  assign sel_err  = !sel_ok;
  assign up_ready = (route == ROUTE_DROP) || ((route == ROUTE_PASS) && dn_ready);
  assign dn_valid = (route == ROUTE_PASS) && up_valid;
  assign dn_data  = up_data;
  assign take     = up_valid && up_ready;

  // R6: an invalid selection blocks both sides
  p_err_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> (!up_ready && !dn_valid));

  // R3: skipping never waits on the sink
  p_skip_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_err && !restart && !own_chunk) |-> (up_ready && !dn_valid));

  // R4: forwarding couples the two handshakes
  p_pass_couple_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_err && !restart && own_chunk) |-> ((up_ready == dn_ready) && (dn_valid == up_valid)));

  // R5: nothing is accepted in a restart cycle
  p_restart_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !up_ready);
endmodule

// File: tb/ilv_image_picker_tb.sv
module ilv_image_picker_tb;
  localparam int CHUNK = 288;
  localparam int WATCHDOG = 180000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       restart = 1'b0;
  logic [3:0] img_count = 4'd1;
  logic [3:0] img_sel = 4'd1;
  logic [7:0] up_data = 8'd0;
  logic       up_valid = 1'b0;
  logic       up_ready;
  logic [7:0] dn_data;
  logic       dn_valid;
  logic       dn_ready = 1'b0;
  logic       sel_err;

  always #2 clk = ~clk;  // 250 MHz

  ilv_image_picker u_dut (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .img_count(img_count), .img_sel(img_sel),
    .up_data(up_data), .up_valid(up_valid), .up_ready(up_ready),
    .dn_data(dn_data), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .sel_err(sel_err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int g = 0;            // bench's own merged-stream index
  int limit = 0;
  bit run = 0;
  bit vmode = 0;
  bit rmode = 0;
  bit took = 0;
  bit restart_seen = 0;
  int cycles = 0;
  logic [15:0] lfsr = 16'hACE1;
  string phase = "R8";
  logic [7:0] expq[$];

  function automatic logic [7:0] byte_of(input int idx);
    int v;
    v = idx * 5 + (idx / CHUNK) * 77;
    return v[7:0];
  endfunction

  function automatic bit legal(input int n, input int s);
    return (n >= 1) && (n <= 8) && (s >= 1) && (s <= n);
  endfunction

  function automatic bit mine(input int idx, input int n, input int s);
    return legal(n, s) && (((idx / CHUNK) % n) == s - 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (g=%0d)", req, act, exp, g);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Driver: moves the bench index and presents the next byte
  always @(posedge clk) begin
    #1;
    cycles++;
    if (cycles > WATCHDOG) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
      finish_run();
    end
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (restart_seen) g = 0;
    else if (took) g = g + 1;
    up_data  <= byte_of(g);
    up_valid <= run && (g < limit) && (!vmode || lfsr[3] || lfsr[7]);
    dn_ready <= !rmode || lfsr[5] || lfsr[1];
  end

  // Monitor and scoreboard, away from the active edge
  always @(negedge clk) begin
    took = 0;
    restart_seen = 0;
    if (rst_n) begin
      automatic int n = int'(img_count);
      automatic int s = int'(img_sel);
      automatic bit keep = mine(g, n, s);
      if (!legal(n, s)) begin
        check(sel_err && !up_ready && !dn_valid, "R6", {sel_err, up_ready, dn_valid}, 3'b100);
      end else begin
        if (sel_err) check(0, "R6", 1, 0);
        if (restart) check(!up_ready, "R5", up_ready, 0);
        else if (up_valid) begin
          if (keep) check(up_ready == dn_ready, "R4", up_ready, dn_ready);
          else check(up_ready && !dn_valid, "R3", {up_ready, dn_valid}, 2'b10);
        end
      end
      took = up_valid && up_ready;
      restart_seen = restart;
      if (took && keep && !restart) expq.push_back(byte_of(g));
      if (dn_valid && dn_ready) begin
        if (expq.size() == 0) check(0, {phase, " R2"}, dn_data, -1);
        else begin
          automatic logic [7:0] e = expq.pop_front();
          check(dn_data == e, {phase, " R2"}, dn_data, e);
        end
      end
    end
  end

  task automatic pulse_restart();
    @(posedge clk); #1;
    restart = 1'b1;
    @(posedge clk); #1;
    restart = 1'b0;
  endtask

  task automatic stream(input int n, input int s, input int len, input bit vm, input bit rm,
                        input string tag);
    phase = tag;
    img_count = 4'(n);
    img_sel = 4'(s);
    vmode = vm;
    rmode = rm;
    pulse_restart();
    limit = len;
    run = 1;
    while (g < limit) @(posedge clk);
    run = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(expq.size() == 0, {tag, " R2"}, expq.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    check(!dn_valid, "R8", dn_valid, 0);
    check(!sel_err, "R8", sel_err, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!dn_valid && g == 0, "R8", dn_valid, 0);

    // R1: middle image of three, two full rounds, with stalls on both sides
    stream(3, 2, 3 * CHUNK * 2 + 50, 1, 1, "R1");
    // R7: single image passes everything
    stream(1, 1, 700, 0, 1, "R7");
    // R9: last of eight images, wrap to round two, random stalls
    stream(8, 8, 8 * CHUNK + 300, 1, 1, "R9");
    // R3: skipping at full rate while the sink is stalled often
    stream(4, 1, 4 * CHUNK + 10, 0, 1, "R3");

    // R5: restart in the middle of the selected chunk, then replay from the top
    phase = "R5";
    img_count = 4'd2;
    img_sel = 4'd2;
    vmode = 0;
    rmode = 0;
    pulse_restart();
    limit = 400;
    run = 1;
    while (g < limit) @(posedge clk);
    run = 0;
    @(negedge clk);
    check(expq.size() == 0, "R5", expq.size(), 0);
    pulse_restart();
    @(negedge clk);
    check(g == 0, "R5", g, 0);
    limit = 2 * CHUNK + 40;
    run = 1;
    while (g < limit) @(posedge clk);
    run = 0;
    repeat (2) @(posedge clk);

    // R6: invalid selections freeze the stream
    phase = "R6";
    pulse_restart();
    img_count = 4'd3;
    img_sel = 4'd0;
    limit = 100;
    run = 1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(g == 0, "R6", g, 0);
    img_sel = 4'd4;
    repeat (5) @(posedge clk);
    img_count = 4'd9;
    img_sel = 4'd1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(g == 0, "R6", g, 0);
    // legal again without restart: first byte still g = 0
    img_count = 4'd3;
    img_sel = 4'd3;
    limit = 3 * CHUNK + 20;
    while (g < limit) @(posedge clk);
    run = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(expq.size() == 0, "R6", expq.size(), 0);

    finish_run();
  end
endmodule